// File: doc/BRIEF.md
# Serial port control register bank

This block is the software-visible register file of a serial port. A simple synchronous bus reaches a small set of 32-bit registers. The control registers hold the soft reset, the clock gate, the port, transmit and receive enables, the request-to-send level, the clear-to-send flow enable, the line settings and the interrupt enables. The bank drives these bits to the serial datapath. In the other direction it collects the datapath's FIFO levels, error events and interrupt events.

Each of the six control registers answers at four addresses: one replaces the register, one ORs in the written ones, one clears them and one inverts them. Software can therefore change single bits without a read-modify-write sequence. Interrupt flags are cleared through the clear address. Error flags are sticky and are cleared by writing ones over them. A character written to the data register is passed to the transmit side as a one-cycle push. A read of the data register pops the receive side.

Top module: `serial_ctl_regs`

## Requirements
- R1: After reset, CTRL0 (0x00) reads 0xC000_0000: soft reset (bit 31) and clock gate (bit 30) are 1. Every other control bit is 0, `irq_o` is 0 and `tx_push_o` is 0.
- R2: A write to a control register's base address (register index in addr[7:4], addr[3:2]=00) replaces the register value. LINECTRL (0x30) appears on `line_ctrl_o`.
- R3: A write to base+0x4 ORs the write data into the register.
- R4: A write to base+0x8 clears the register bits that are 1 in the write data.
- R5: A write to base+0xC inverts the register bits that are 1 in the write data.
- R6: A read returns its data on `rdata_o` in the cycle after the request. A read at any of the four addresses of a control register returns the current value.
- R7: CTRL0 bit 31 drives `soft_rst_o` and bit 30 drives `clk_gate_o`. CTRL2 (0x20) bit 0 drives `port_en_o`, bit 8 `tx_en_o`, bit 9 `rx_en_o`, bit 11 `rts_o` and bit 15 `cts_flow_en_o`.
- R8: INTR (0x50) keeps only bits 22, 21, 20, 17 (enables) and 6, 5, 4, 1 (flags). A pulse on `irq_src_i[3]` (receive timeout), `[2]` (transmit), `[1]` (receive) or `[0]` (CTS change) sets flag bit 6, 5, 4 or 1. Writing ones to 0x58 clears flags. When a hardware pulse and a clear hit the same flag in one cycle, the flag ends up set.
- R9: `irq_o` is high exactly when some INTR flag is 1 and its enable (flag position + 16) is also 1.
- R10: STAT (0x70) reports `busy_i` at bit 29, `cts_i` at 28, `tx_empty_i` at 27, `tx_full_i` at 25 and `rx_empty_i` at 24. A pulse on `err_i[3]` (overrun), `[2]` (break), `[1]` (parity) or `[0]` (framing) sets sticky bit 19, 18, 17 or 16. Writing 1 to that bit at 0x70 clears it, and a new event in the same cycle wins.
- R11: Writes to the set, clear or toggle offsets of DATA, STAT, DEBUG, VERSION or AUTOBAUD are ignored. DEBUG (0x80), AUTOBAUD (0xA0) and unmapped addresses read 0.
- R12: VERSION (0x90) is read-only and returns major in [31:23+1], minor in [23:16] and step in [15:0], all set by parameters.
- R13: A write to 0x60 raises `tx_push_o` for one cycle, starting the cycle after, with `tx_data_o` equal to the low write-data byte. A read of 0x60 raises `rx_pop_o` in the request cycle and returns `rx_data_i` in `rdata_o` bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| soft_rst_o | output | 1 | Datapath soft reset |
| clk_gate_o | output | 1 | Datapath clock gate |
| port_en_o | output | 1 | Port enable |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| rts_o | output | 1 | Request-to-send level |
| cts_flow_en_o | output | 1 | CTS flow control enable |
| line_ctrl_o | output | 32 | Line control word |
| irq_src_i | input | 4 | Interrupt event pulses |
| err_i | input | 4 | Error event pulses |
| busy_i | input | 1 | Transmitter busy |
| cts_i | input | 1 | CTS pin level |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_full_i | input | 1 | Transmit FIFO full |
| rx_empty_i | input | 1 | Receive FIFO empty |
| tx_push_o | output | 1 | Transmit character strobe |
| tx_data_o | output | CHAR_W | Transmit character |
| rx_pop_o | output | 1 | Receive character strobe |
| rx_data_i | input | CHAR_W | Receive character |
| irq_o | output | 1 | Interrupt request |

## Verification
Each register and flag is updated at the edge that accepts the write or event. Its effect on the control outputs, `irq_o` and `tx_push_o` is therefore due one cycle after the stimulus. Read data is registered and is due in the cycle after the read request, while `rx_pop_o` is combinational and valid during the request cycle. The bench drives each access at the falling edge and samples results 1 ns after the next rising edge. It checks `rx_pop_o` before that edge. Each read is issued only after the write it observes has taken effect.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;
  localparam int REG_W   = 32;
  localparam int N_ALIAS = 6;
  localparam int N_IRQ   = 4;
  localparam int N_ERR   = 4;

  typedef enum logic [1:0] {OP_WR = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_TOG = 2'd3} alias_op_e;

  // register index = addr[7:4]
  localparam int A_CTRL0 = 0;
  localparam int A_CTRL1 = 1;
  localparam int A_CTRL2 = 2;
  localparam int A_LINE  = 3;
  localparam int A_LINE2 = 4;
  localparam int A_INTR  = 5;
  localparam int A_DATA  = 6;
  localparam int A_STAT  = 7;
  localparam int A_DBG   = 8;
  localparam int A_VER   = 9;
  localparam int A_ABAUD = 10;

  localparam int B_SRST    = 31;
  localparam int B_GATE    = 30;
  localparam int B_PORT_EN = 0;
  localparam int B_TX_EN   = 8;
  localparam int B_RX_EN   = 9;
  localparam int B_RTS     = 11;
  localparam int B_CTS_EN  = 15;
  localparam int IRQ_EN_OFS = 16;

  localparam int B_BUSY  = 29;
  localparam int B_CTS   = 28;
  localparam int B_TXFE  = 27;
  localparam int B_TXFF  = 25;
  localparam int B_RXFE  = 24;
  localparam int ERR_LSB = 16;

  // irq source k -> flag bit
  function automatic int flag_pos(input int k);
    case (k)
      0:       return 1;
      1:       return 4;
      2:       return 5;
      default: return 6;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] intr_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < N_IRQ; k++) begin
      m[flag_pos(k)] = 1'b1;
      m[flag_pos(k) + IRQ_EN_OFS] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [REG_W-1:0] alias_rst(input int idx);
    logic [REG_W-1:0] v;
    v = '0;
    if (idx == A_CTRL0) begin
      v[B_SRST] = 1'b1;
      v[B_GATE] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [REG_W-1:0] alias_mask(input int idx);
    return (idx == A_INTR) ? intr_mask() : '1;
  endfunction

  function automatic logic [REG_W-1:0] alias_apply(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] d,
                                                   input alias_op_e op);
    case (op)
      OP_WR:   return d;
      OP_SET:  return cur | d;
      OP_CLR:  return cur & ~d;
      default: return cur ^ d;
    endcase
  endfunction
endpackage

// File: rtl/serial_ctl_sct_reg.sv
module serial_ctl_sct_reg
  import serial_ctl_pkg::*;
#(
  parameter logic [REG_W-1:0] RST  = '0,
  parameter logic [REG_W-1:0] MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  alias_op_e        op_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] hw_set_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] sw_d;

  always_comb begin
    sw_d = q_o;
    if (wr_i) sw_d = alias_apply(q_o, wdata_i, op_i) & MASK;
  end

  // hardware events override a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST;
    else         q_o <= sw_d | (hw_set_i & MASK);
  end
endmodule

// File: rtl/serial_ctl_stat.sv
module serial_ctl_stat
  import serial_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [N_ERR-1:0] clr_mask_i,
  input  logic [N_ERR-1:0] err_i,
  input  logic             busy_i,
  input  logic             cts_i,
  input  logic             tx_empty_i,
  input  logic             tx_full_i,
  input  logic             rx_empty_i,
  output logic [N_ERR-1:0] err_q_o,
  output logic [REG_W-1:0] stat_o
);
  logic [N_ERR-1:0] clr_bits;
  assign clr_bits = clr_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q_o <= '0;
    else         err_q_o <= (err_q_o & ~clr_bits) | err_i;
  end

  always_comb begin
    stat_o = '0;
    stat_o[B_BUSY] = busy_i;
    stat_o[B_CTS]  = cts_i;
    stat_o[B_TXFE] = tx_empty_i;
    stat_o[B_TXFF] = tx_full_i;
    stat_o[B_RXFE] = rx_empty_i;
    stat_o[ERR_LSB +: N_ERR] = err_q_o;
  end
endmodule

// File: rtl/serial_ctl_data.sv
module serial_ctl_data #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] wdata_i,
  output logic              tx_push_o,
  output logic [CHAR_W-1:0] tx_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_push_o <= 1'b0;
      tx_data_o <= '0;
    end else begin
      tx_push_o <= wr_i;
      if (wr_i) tx_data_o <= wdata_i;
    end
  end
endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import serial_ctl_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          CHAR_W    = 8,
  parameter logic [7:0]  VER_MAJOR = 8'd2,
  parameter logic [7:0]  VER_MINOR = 8'd1,
  parameter logic [15:0] VER_STEP  = 16'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              soft_rst_o,
  output logic              clk_gate_o,
  output logic              port_en_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              rts_o,
  output logic              cts_flow_en_o,
  output logic [REG_W-1:0]  line_ctrl_o,
  input  logic [N_IRQ-1:0]  irq_src_i,
  input  logic [N_ERR-1:0]  err_i,
  input  logic              busy_i,
  input  logic              cts_i,
  input  logic              tx_empty_i,
  input  logic              tx_full_i,
  input  logic              rx_empty_i,
  output logic              tx_push_o,
  output logic [CHAR_W-1:0] tx_data_o,
  output logic              rx_pop_o,
  input  logic [CHAR_W-1:0] rx_data_i,
  output logic              irq_o
);
  localparam int IDX_LSB = 4;
  localparam int IDX_W   = ADDR_W - IDX_LSB;
  localparam logic [REG_W-1:0] VER_WORD = {VER_MAJOR, VER_MINOR, VER_STEP};

  logic [IDX_W-1:0] reg_idx;
  alias_op_e        op;
  logic             wr_en, rd_en, base_op;
  logic [N_ALIAS-1:0] wr_sel;
  logic [REG_W-1:0] areg_q [N_ALIAS];
  logic [REG_W-1:0] intr_hw_set, intr_q, stat_val, rd_val;
  logic [N_ERR-1:0] err_q;
  logic             unused_addr;

  assign reg_idx     = addr_i[ADDR_W-1:IDX_LSB];
  assign op          = alias_op_e'(addr_i[3:2]);
  assign unused_addr = ^addr_i[1:0];
  assign wr_en       = req_i && we_i;
  assign rd_en       = req_i && !we_i;
  assign base_op     = (op == OP_WR);

  always_comb begin
    intr_hw_set = '0;
    for (int k = 0; k < N_IRQ; k++) intr_hw_set[flag_pos(k)] = irq_src_i[k];
  end

  for (genvar g = 0; g < N_ALIAS; g++) begin : g_alias
    logic [REG_W-1:0] hw;
    assign wr_sel[g] = wr_en && (reg_idx == IDX_W'(g));
    if (g == A_INTR) begin : g_hw
      assign hw = intr_hw_set;
    end else begin : g_nohw
      assign hw = '0;
    end
    serial_ctl_sct_reg #(
      .RST (alias_rst(g)),
      .MASK(alias_mask(g))
    ) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_sel[g]),
      .op_i    (op),
      .wdata_i (wdata_i),
      .hw_set_i(hw),
      .q_o     (areg_q[g])
    );
  end

  assign intr_q = areg_q[A_INTR];

  serial_ctl_stat u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (wr_en && base_op && (reg_idx == IDX_W'(A_STAT))),
    .clr_mask_i(wdata_i[ERR_LSB +: N_ERR]),
    .err_i     (err_i),
    .busy_i    (busy_i),
    .cts_i     (cts_i),
    .tx_empty_i(tx_empty_i),
    .tx_full_i (tx_full_i),
    .rx_empty_i(rx_empty_i),
    .err_q_o   (err_q),
    .stat_o    (stat_val)
  );

  serial_ctl_data #(.CHAR_W(CHAR_W)) u_data (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en && base_op && (reg_idx == IDX_W'(A_DATA))),
    .wdata_i  (wdata_i[CHAR_W-1:0]),
    .tx_push_o(tx_push_o),
    .tx_data_o(tx_data_o)
  );

  assign rx_pop_o = rd_en && base_op && (reg_idx == IDX_W'(A_DATA));

  assign soft_rst_o    = areg_q[A_CTRL0][B_SRST];
  assign clk_gate_o    = areg_q[A_CTRL0][B_GATE];
  assign port_en_o     = areg_q[A_CTRL2][B_PORT_EN];
  assign tx_en_o       = areg_q[A_CTRL2][B_TX_EN];
  assign rx_en_o       = areg_q[A_CTRL2][B_RX_EN];
  assign rts_o         = areg_q[A_CTRL2][B_RTS];
  assign cts_flow_en_o = areg_q[A_CTRL2][B_CTS_EN];
  assign line_ctrl_o   = areg_q[A_LINE];

  always_comb begin
    irq_o = 1'b0;
    for (int k = 0; k < N_IRQ; k++)
      irq_o = irq_o | (intr_q[flag_pos(k)] & intr_q[flag_pos(k) + IRQ_EN_OFS]);
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_ALIAS; i++)
      if (reg_idx == IDX_W'(i)) rd_val = areg_q[i];
    if (reg_idx == IDX_W'(A_DATA)) rd_val = REG_W'(rx_data_i);
    if (reg_idx == IDX_W'(A_STAT)) rd_val = stat_val;
    if (reg_idx == IDX_W'(A_VER))  rd_val = VER_WORD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_val;
  end
endmodule

// File: rtl/serial_ctl_regs_chk.sv
module serial_ctl_regs_chk #(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] VER_WORD = 32'h0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              port_en_o,
  input logic              tx_en_o,
  input logic              tx_push_o,
  input logic              irq_o,
  input logic [3:0]        irq_src_i,
  input logic [3:0]        err_i,
  input logic [31:0]       intr_q,
  input logic [3:0]        err_q
);
  logic       wr, rd;
  logic [7:0] a8;
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;
  assign a8 = {addr_i[7:2], 2'b00};

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && a8 == 8'h24 && wdata_i[0] |=> port_en_o);

  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && a8 == 8'h28 && wdata_i[0] |=> !port_en_o);

  p_tog_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && a8 == 8'h2C && wdata_i[8] |=> tx_en_o != $past(tx_en_o));

  p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_src_i[2] |=> intr_q[5]);

  p_irq_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(wr) || $past(|irq_src_i));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != 4'b0) && !(wr && a8 == 8'h70) |=> (err_q & $past(err_q)) == $past(err_q));

  p_stat_alias_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i[7:4] == 4'h7 && addr_i[3:2] != 2'b00 && err_i == 4'b0 |=> $stable(err_q));

  p_version_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && addr_i[7:4] == 4'h9 |=> rdata_o == VER_WORD);

  p_push_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && a8 == 8'h60 |=> tx_push_o);
endmodule

bind serial_ctl_regs serial_ctl_regs_chk #(
  .ADDR_W  (ADDR_W),
  .VER_WORD({VER_MAJOR, VER_MINOR, VER_STEP})
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .port_en_o(port_en_o),
  .tx_en_o  (tx_en_o),
  .tx_push_o(tx_push_o),
  .irq_o    (irq_o),
  .irq_src_i(irq_src_i),
  .err_i    (err_i),
  .intr_q   (intr_q),
  .err_q    (err_q)
);

// File: tb/serial_ctl_regs_bench.sv
`timescale 1ns/1ps
module serial_ctl_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, line_ctrl_o;
  logic        soft_rst_o, clk_gate_o, port_en_o, tx_en_o, rx_en_o, rts_o, cts_flow_en_o;
  logic [3:0]  irq_src_i = '0, err_i = '0;
  logic        busy_i = 1'b1, cts_i = 1'b0, tx_empty_i = 1'b1, tx_full_i = 1'b0, rx_empty_i = 1'b1;
  logic        tx_push_o, rx_pop_o, irq_o;
  logic [7:0]  tx_data_o, rx_data_i = '0;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  serial_ctl_regs u_serial_ctl_regs (.*);

  typedef struct packed {
    logic [7:0]  waddr;
    logic [31:0] wdat;
    logic [7:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 32'hA5A5_0F0F, 8'h10, 32'hA5A5_0F0F, 4'd2},  // R2
    '{8'h14, 32'h0000_F0F0, 8'h10, 32'hA5A5_FFFF, 4'd3},  // R3
    '{8'h18, 32'hA000_000F, 8'h10, 32'h05A5_FFF0, 4'd4},  // R4
    '{8'h1C, 32'hFFFF_0000, 8'h10, 32'hFA5A_FFF0, 4'd5},  // R5
    '{8'h10, 32'h1234_5678, 8'h14, 32'h1234_5678, 4'd6},  // R6
    '{8'h30, 32'h0000_0070, 8'h38, 32'h0000_0070, 4'd6},  // R6
    '{8'h50, 32'hFFFF_FFFF, 8'h50, 32'h0072_0072, 4'd8},  // R8
    '{8'h58, 32'hFFFF_FFFF, 8'h5C, 32'h0000_0000, 4'd8},  // R8
    '{8'h74, 32'hFFFF_FFFF, 8'h70, 32'h2900_0000, 4'd11}, // R11
    '{8'h90, 32'hFFFF_FFFF, 8'h90, 32'h0201_0003, 4'd12}, // R12
    '{8'hA0, 32'h0000_0001, 8'hA4, 32'h0000_0000, 4'd11}, // R11
    '{8'h20, 32'h0000_8B01, 8'h20, 32'h0000_8B01, 4'd7}   // R7
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic pop);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 pop = rx_pop_o;
    @(posedge clk_i); #1;
    d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk_i);
    @(posedge clk_i); #1;
  endtask

  initial begin
    logic [31:0] d;
    logic        p;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #1;
    // R1 reset state
    check("R1 soft_rst", 32'(soft_rst_o), 32'd1);
    check("R1 clk_gate", 32'(clk_gate_o), 32'd1);
    check("R1 ctrl2 bits", {27'd0, port_en_o, tx_en_o, rx_en_o, rts_o, cts_flow_en_o}, 32'd0);
    check("R1 irq/push", {30'd0, irq_o, tx_push_o}, 32'd0);
    bus_rd(8'h00, d, p); check("R1 ctrl0 read", d, 32'hC000_0000);
    bus_rd(8'h20, d, p); check("R1 ctrl2 read", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_wr(VECS[i].waddr, VECS[i].wdat);
      bus_rd(VECS[i].raddr, d, p);
      check($sformatf("R%0d vector %0d", VECS[i].rq, i), d, VECS[i].exp);
    end

    // R7 control outputs after CTRL2 = 0x8B01, R2 line control
    check("R7 ctrl2 pins", {27'd0, port_en_o, tx_en_o, rx_en_o, rts_o, cts_flow_en_o}, 32'h1F);
    check("R2 line_ctrl_o", line_ctrl_o, 32'h70);
    bus_wr(8'h2C, 32'h0000_0200);  // R5 toggle receive enable off
    check("R5 rx_en toggled", {30'd0, rx_en_o, tx_en_o}, 32'b01);

    // R7 soft reset / clock gate release sequence
    bus_wr(8'h08, 32'h8000_0000);
    check("R7 soft_rst clr", {30'd0, soft_rst_o, clk_gate_o}, 32'b01);
    bus_rd(8'h00, d, p); check("R4 ctrl0 read", d, 32'h4000_0000);
    bus_wr(8'h08, 32'h4000_0000);
    check("R7 clk_gate clr", 32'(clk_gate_o), 32'd0);

    // R8 / R9 interrupt flags
    @(negedge clk_i) irq_src_i = 4'b0100;
    @(posedge clk_i); #1 irq_src_i = 4'b0000;
    bus_rd(8'h50, d, p); check("R8 tx flag set", d, 32'h0000_0020);
    check("R9 irq masked", 32'(irq_o), 32'd0);
    bus_wr(8'h54, 32'h0020_0000);
    check("R9 irq enabled", 32'(irq_o), 32'd1);
    bus_wr(8'h58, 32'h0000_0020);
    check("R9 irq after clear", 32'(irq_o), 32'd0);
    irq_src_i = 4'b0010;
    bus_wr(8'h58, 32'h0000_0010);
    irq_src_i = 4'b0000;
    bus_rd(8'h50, d, p); check("R8 hw set wins", d, 32'h0020_0010);

    // R10 / R11 sticky errors
    @(negedge clk_i) err_i = 4'b1010;
    @(posedge clk_i); #1 err_i = 4'b0000;
    bus_rd(8'h70, d, p); check("R10 errors set", d, 32'h290A_0000);
    bus_wr(8'h78, 32'hFFFF_FFFF);
    bus_rd(8'h70, d, p); check("R11 stat alias ignored", d, 32'h290A_0000);
    bus_wr(8'h70, 32'h0008_0000);
    bus_rd(8'h70, d, p); check("R10 overrun cleared", d, 32'h2902_0000);
    cts_i = 1'b1; tx_full_i = 1'b1;
    bus_rd(8'h70, d, p); check("R10 live status", d, 32'h3B02_0000);

    // R13 data register
    bus_wr(8'h60, 32'h1234_56C3);
    check("R13 push", {23'd0, tx_push_o, tx_data_o}, 32'h1C3);
    idle_cycle();
    check("R13 push one cycle", 32'(tx_push_o), 32'd0);
    rx_data_i = 8'h5A;
    bus_rd(8'h60, d, p);
    check("R13 pop", 32'(p), 32'd1);
    check("R13 rx data", d, 32'h0000_005A);
    bus_rd(8'h80, d, p); check("R11 debug reads 0", d, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule